// File: doc/BRIEF.md
# Program Trace Compression Filter

This block sits between the program-trace outputs of a processor core and a trace memory. Each clock it receives a five-bit status word describing what the core reported that cycle. On an indirect change of flow it also receives the fetch target address captured on that show cycle. Instructions that the core later reports as cancelled are discarded. What reaches memory is a stream of compact records: branch taken, branch not taken, indirect change of flow with its 30-bit target, and a plain "sequential run" record used only when the run counter would wrap. Each record carries the number of sequential instructions that completed since the previous record.

Every status stays in a two-stage holding window before it is committed, so that a cancel arriving within two clocks can still retract it. Committed records enter a four-entry queue that drains through a valid/ready handshake. When that queue is full, further records are dropped. A sticky flag reports the loss, and the first record accepted after a drop is marked.

Top module: `trc_compress`

## Requirements
- R1: After a synchronous reset, `rec_valid` and `ovf_sticky` are low, the run count is zero and the window and queue are empty.
- R2: Status `st_code = {issue[1:0], kind[2:0]}`. Kinds 001, 010, 011 and 100 are live window entries. Kind 101 is a cancel: it adds no entry and retracts the `issue` newest live entries still in the window, newest first. An issue of 0 retracts nothing, and 2 or 3 retract both stages. A retracted entry produces no record and adds nothing to the count.
- R3: A committed kind 010 (taken) produces a record of kind 01, and a committed kind 011 (not taken) produces a record of kind 10. In both cases the target field is zero.
- R4: A committed kind 100 (indirect) produces a record of kind 11 whose target is the `st_addr` value sampled with that status.
- R5: The count field of a record equals the sum of the issue values of committed kind 001 statuses since the previous record, and the count then returns to zero. The branch itself is not counted. Kinds 000, 110 and 111 change nothing.
- R6: A status sampled at clock edge k commits at edge k+2. A cancel sampled at edge k+1 or k+2 can retract it; a cancel sampled at a later edge cannot. When the queue is empty, the record is valid immediately after edge k+2.
- R7: If adding a sequential issue value would take the 16-bit count past 65535, a record of kind 00 is emitted. It carries the count before the addition and a zero target, and the count restarts at that issue value.
- R8: Records leave in commit order through a queue of four. `rec_data = {kind[47:46], count[45:30], target[29:0]}` and `rec_lost` stay stable while `rec_valid` is high and `rec_ready` is low.
- R9: A record produced while four records are held and none leaves that cycle is discarded, and `ovf_sticky` goes high and stays high until reset.
- R10: The first record accepted after a discard has `rec_lost` high. All other records have it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_code | input | 5 | Per-clock status {issue, kind} |
| st_addr | input | 30 | Target address, used with an indirect status |
| rec_valid | output | 1 | A record is available |
| rec_ready | input | 1 | Sink accepts the record this cycle |
| rec_data | output | 48 | Record {kind, count, target} |
| rec_lost | output | 1 | Records were discarded just before this one |
| ovf_sticky | output | 1 | A record has been discarded since reset |

## Verification
A window stage that retains an entry it should have dropped, or drops one it should have kept, shows up at the ports two clocks later as an extra or missing record, or as a count that is off by that entry's issue value. A run counter that is not cleared surfaces in the count field of the very next record. A queue pointer or occupancy error shows as reordered, repeated or missing records as soon as the sink applies back-pressure. The bench compares every clock against a model built from the requirements, so any such fault is reported in the cycle it first reaches the output.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int ADDR_W = 30;
    localparam int SEQ_W  = 16;
    localparam int REC_W  = 2 + SEQ_W + ADDR_W;

    localparam logic [2:0] K_IDLE   = 3'b000;
    localparam logic [2:0] K_SEQ    = 3'b001;
    localparam logic [2:0] K_TAKEN  = 3'b010;
    localparam logic [2:0] K_NTAKEN = 3'b011;
    localparam logic [2:0] K_IND    = 3'b100;
    localparam logic [2:0] K_CANCEL = 3'b101;

    typedef enum logic [1:0] {
        RK_RUN    = 2'b00,
        RK_TAKEN  = 2'b01,
        RK_NTAKEN = 2'b10,
        RK_IND    = 2'b11
    } rec_kind_e;

    typedef struct packed {
        logic              live;
        logic [2:0]        kind;
        logic [1:0]        issue;
        logic [ADDR_W-1:0] addr;
    } win_ent_t;

    typedef struct packed {
        rec_kind_e         kind;
        logic [SEQ_W-1:0]  seq;
        logic [ADDR_W-1:0] target;
    } rec_t;

    typedef struct packed {
        logic lost;
        rec_t rec;
    } q_ent_t;

    function automatic logic occupies_window(input logic [2:0] k);
        return (k == K_SEQ) || (k == K_TAKEN) || (k == K_NTAKEN) || (k == K_IND);
    endfunction

    function automatic rec_kind_e flow_kind(input logic [2:0] k);
        case (k)
            K_TAKEN:  return RK_TAKEN;
            K_NTAKEN: return RK_NTAKEN;
            default:  return RK_IND;
        endcase
    endfunction
endpackage

// File: rtl/trc_window.sv
module trc_window
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        st_kind,
    input  logic [1:0]        st_issue,
    input  logic [ADDR_W-1:0] st_addr,
    output win_ent_t          commit
);
    win_ent_t s0_q, s1_q, incoming;
    logic     is_cancel, kill0, kill1;

    assign is_cancel = (st_kind == K_CANCEL);

    // retract newest live entries first
    always_comb begin
        kill0 = 1'b0;
        kill1 = 1'b0;
        if (is_cancel) begin
            if (st_issue >= 2'd2) begin
                kill0 = 1'b1;
                kill1 = 1'b1;
            end else if (st_issue == 2'd1) begin
                if (s0_q.live) kill0 = 1'b1;
                else           kill1 = 1'b1;
            end
        end
    end

    always_comb begin
        incoming.live  = occupies_window(st_kind);
        incoming.kind  = st_kind;
        incoming.issue = st_issue;
        incoming.addr  = st_addr;
        commit         = s1_q;
        commit.live    = s1_q.live & ~kill1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_q <= '0;
            s1_q <= '0;
        end else begin
            s1_q      <= s0_q;
            s1_q.live <= s0_q.live & ~kill0;
            s0_q      <= incoming;
        end
    end

    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (is_cancel && st_issue >= 2'd2) |=> (!s0_q.live && !s1_q.live)); // R2
endmodule

// File: rtl/trc_runlen.sv
module trc_runlen
    import trc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  win_ent_t commit,
    output logic     push,
    output rec_t     rec
);
    logic [SEQ_W-1:0] run_q, run_d;
    logic [SEQ_W:0]   sum;

    assign sum = {1'b0, run_q} + {{(SEQ_W-1){1'b0}}, commit.issue};

    always_comb begin
        push       = 1'b0;
        rec.kind   = RK_RUN;
        rec.seq    = run_q;
        rec.target = '0;
        run_d      = run_q;
        if (commit.live) begin
            if (commit.kind == K_SEQ) begin
                if (sum[SEQ_W]) begin
                    push  = 1'b1;
                    run_d = {{(SEQ_W-2){1'b0}}, commit.issue};
                end else begin
                    run_d = sum[SEQ_W-1:0];
                end
            end else begin
                push     = 1'b1;
                rec.kind = flow_kind(commit.kind);
                if (commit.kind == K_IND) rec.target = commit.addr;
                run_d    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_d;
    end

    AST_FLOW_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (push && rec.kind != RK_RUN) |=> (run_q == '0)); // R5
    AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (push && rec.kind == RK_RUN) |=> (run_q != '0)); // R7
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
    import trc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  rec_t rec_in,
    input  logic ready,
    output logic valid,
    output rec_t head,
    output logic head_lost,
    output logic sticky
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    q_ent_t        mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          mark_q, full, do_pop, accept, drop;

    assign full   = (cnt_q == CW'(DEPTH));
    assign valid  = (cnt_q != '0);
    assign do_pop = valid & ready;
    assign accept = push & (~full | do_pop);
    assign drop   = push & full & ~do_pop;
    assign head      = mem[rd_q].rec;
    assign head_lost = mem[rd_q].lost;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            mark_q <= 1'b0;
            sticky <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept) begin
                mem[wr_q] <= '{lost: mark_q, rec: rec_in};
                wr_q      <= bump(wr_q);
                mark_q    <= 1'b0;
            end
            if (drop) begin
                mark_q <= 1'b1;
                sticky <= 1'b1;
            end
            if (do_pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(accept) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(head) && $stable(head_lost))); // R8
    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        sticky |=> sticky); // R9
endmodule

// File: rtl/trc_compress.sv
module trc_compress
    import trc_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        st_code,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [REC_W-1:0]  rec_data,
    output logic              rec_lost,
    output logic              ovf_sticky
);
    win_ent_t commit;
    logic     push;
    rec_t     rec, head;

    trc_window u_win (
        .clk      (clk),
        .rst      (rst),
        .st_kind  (st_code[2:0]),
        .st_issue (st_code[4:3]),
        .st_addr  (st_addr),
        .commit   (commit)
    );

    trc_runlen u_run (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .push   (push),
        .rec    (rec)
    );

    trc_fifo #(.DEPTH(QUEUE_DEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .rec_in    (rec),
        .ready     (rec_ready),
        .valid     (rec_valid),
        .head      (head),
        .head_lost (rec_lost),
        .sticky    (ovf_sticky)
    );

    assign rec_data = head;

    AST_TARGET_ONLY_IND: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_data[REC_W-1 -: 2] != 2'b11) |-> (rec_data[ADDR_W-1:0] == '0)); // R3
endmodule

// File: tb/sim_trc_compress.sv
module sim_trc_compress;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  st_code = '0;
    logic [29:0] st_addr = '0;
    logic        rec_ready = 1'b0;
    logic        rec_valid, rec_lost, ovf_sticky;
    logic [47:0] rec_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    trc_compress u0 (
        .clk(clk), .rst(rst), .st_code(st_code), .st_addr(st_addr),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
        .rec_lost(rec_lost), .ovf_sticky(ovf_sticky)
    );

    always #10 clk = ~clk;

    // model state, derived from the requirements
    logic        m0_live = 0, m1_live = 0;
    logic [2:0]  m0_kind = 0, m1_kind = 0;
    logic [1:0]  m0_iss = 0, m1_iss = 0;
    logic [29:0] m0_addr = 0, m1_addr = 0;
    int          m_run = 0;
    logic        m_mark = 0, m_sticky = 0;
    logic [48:0] mq[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] sc(input int iss, input int kind);
        return {iss[1:0], kind[2:0]};
    endfunction

    task automatic model_update(input logic [4:0] code, input logic [29:0] addr, input logic rdy);
        logic [2:0]  k;
        logic [1:0]  n;
        bit          k0, k1, push, full, pop;
        logic [47:0] r;
        k = code[2:0]; n = code[4:3];
        k0 = 0; k1 = 0; push = 0; r = '0;
        if (k == 3'd5) begin
            if (n >= 2) begin k0 = 1; k1 = 1; end
            else if (n == 1) begin if (m0_live) k0 = 1; else k1 = 1; end
        end
        if (m1_live && !k1) begin
            if (m1_kind == 3'd1) begin
                if (m_run + int'(m1_iss) > 65535) begin
                    push = 1; r = {2'b00, m_run[15:0], 30'd0}; m_run = int'(m1_iss);
                end else m_run += int'(m1_iss);
            end else begin
                push = 1;
                case (m1_kind)
                    3'd2:    r = {2'b01, m_run[15:0], 30'd0};
                    3'd3:    r = {2'b10, m_run[15:0], 30'd0};
                    default: r = {2'b11, m_run[15:0], m1_addr};
                endcase
                m_run = 0;
            end
        end
        full = (mq.size() == 4);
        pop  = rdy && (mq.size() > 0);
        if (pop) void'(mq.pop_front());
        if (push) begin
            if (!full || pop) begin mq.push_back({m_mark, r}); m_mark = 0; end
            else begin m_mark = 1; m_sticky = 1; end
        end
        m1_live = m0_live && !k0; m1_kind = m0_kind; m1_iss = m0_iss; m1_addr = m0_addr;
        m0_live = (k >= 3'd1 && k <= 3'd4); m0_kind = k; m0_iss = n; m0_addr = addr;
    endtask

    task automatic compare();
        string tag;
        chk(rec_valid == (mq.size() > 0), "R8 valid", 64'(rec_valid), 64'(mq.size() > 0));
        if (rec_valid && mq.size() > 0) begin
            case (mq[0][47:46])
                2'b00:   tag = "R7 record";
                2'b11:   tag = "R4 record";
                default: tag = "R3 record";
            endcase
            chk(rec_data == mq[0][47:0], tag, 64'(rec_data), 64'(mq[0][47:0]));
            chk(rec_lost == mq[0][48], "R10 lost", 64'(rec_lost), 64'(mq[0][48]));
        end
        chk(ovf_sticky == m_sticky, "R9 sticky", 64'(ovf_sticky), 64'(m_sticky));
    endtask

    task automatic step(input logic [4:0] code, input logic [29:0] addr, input logic rdy);
        st_code = code; st_addr = addr; rec_ready = rdy;
        @(posedge clk);
        model_update(code, addr, rdy);
        @(negedge clk);
        compare();
    endtask

    task automatic expect_rec(input logic [1:0] k, input int seq, input logic [29:0] tgt,
                              input logic lost, input string tag);
        logic [48:0] e;
        e = {lost, k, seq[15:0], tgt};
        chk(rec_valid && {rec_lost, rec_data} == e, tag, 64'({rec_valid, rec_lost, rec_data}), 64'({1'b1, e}));
    endtask

    task automatic expect_empty(input string tag);
        chk(!rec_valid, tag, 64'(rec_valid), 64'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_err++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!rec_valid && !ovf_sticky, "R1 reset", 64'({rec_valid, ovf_sticky}), 64'd0);

        // R5 / R6: counting, ignored codes, commit latency
        step(sc(3, 1), 0, 1);
        step(sc(2, 6), 30'h1234, 1);
        step(sc(2, 1), 0, 1);
        step(sc(0, 2), 0, 1);
        step(sc(0, 0), 0, 1);
        expect_empty("R6 not before k+2");
        step(sc(0, 0), 0, 1);
        expect_rec(2'b01, 5, 0, 0, "R5 count 3+2");
        step(sc(0, 0), 0, 1);

        // R2: cancel of the newest entry
        step(sc(3, 1), 0, 1);
        step(sc(0, 4), 30'h2AAA_5555, 1);
        step(sc(1, 5), 0, 1);
        step(sc(0, 0), 0, 1);
        step(sc(0, 0), 0, 1);
        step(sc(0, 0), 0, 1);
        expect_empty("R2 cancelled indirect");
        step(sc(0, 2), 0, 1);
        step(sc(0, 0), 0, 1);
        step(sc(0, 0), 0, 1);
        expect_rec(2'b01, 3, 0, 0, "R2 count survives");
        step(sc(0, 0), 0, 1);

        // R4 / R6: window boundary with back-pressure
        step(sc(0, 4), 30'h0ABC_DEF1, 0);
        step(sc(0, 0), 0, 0);
        step(sc(0, 0), 0, 0);
        expect_rec(2'b11, 0, 30'h0ABC_DEF1, 0, "R4 indirect target");
        step(sc(2, 5), 0, 0);
        expect_rec(2'b11, 0, 30'h0ABC_DEF1, 0, "R6 late cancel ignored");
        step(sc(0, 4), 30'h1111_2222, 0);
        step(sc(0, 0), 0, 0);
        step(sc(1, 5), 0, 0);
        step(sc(0, 0), 0, 0);
        step(sc(0, 0), 0, 0);
        step(sc(0, 0), 0, 1);
        expect_empty("R2 cancel reaches older stage");

        // R9 / R10: queue overflow
        for (int i = 0; i < 5; i++) step(sc(0, 3), 0, 0);
        step(sc(0, 0), 0, 0);
        step(sc(0, 0), 0, 0);
        chk(ovf_sticky, "R9 sticky set", 64'(ovf_sticky), 64'd1);
        for (int i = 0; i < 4; i++) begin
            expect_rec(2'b10, 0, 0, 0, "R8 drain in order");
            step(sc(0, 0), 0, 1);
        end
        expect_empty("R9 fifth record discarded");
        step(sc(0, 2), 0, 1);
        step(sc(0, 0), 0, 1);
        step(sc(0, 0), 0, 1);
        expect_rec(2'b01, 0, 0, 1, "R10 marker after drop");
        step(sc(0, 2), 0, 1);
        step(sc(0, 0), 0, 1);
        step(sc(0, 0), 0, 1);
        expect_rec(2'b01, 0, 0, 0, "R10 marker cleared");
        chk(ovf_sticky, "R9 sticky held", 64'(ovf_sticky), 64'd1);
        step(sc(0, 0), 0, 1);

        // R7: run counter wrap
        for (int i = 0; i < 21845; i++) step(sc(3, 1), 0, 1);
        step(sc(1, 1), 0, 1);
        step(sc(0, 2), 0, 1);
        step(sc(0, 0), 0, 1);
        expect_rec(2'b00, 65535, 0, 0, "R7 run record");
        step(sc(0, 0), 0, 1);
        expect_rec(2'b01, 1, 0, 0, "R7 restart count");
        step(sc(0, 0), 0, 1);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r, kind;
            logic rdy;
            r = $urandom % 16;
            if (r < 2) kind = 0;
            else if (r < 7) kind = 1;
            else if (r < 9) kind = 2;
            else if (r < 11) kind = 3;
            else if (r < 13) kind = 4;
            else if (r < 15) kind = 5;
            else kind = 6 + ($urandom % 2);
            rdy = ((i / 60) % 4 == 1) ? 1'b0 : (($urandom % 4) != 0);
            step(sc($urandom % 4, kind), 30'($urandom), rdy);
        end
        for (int i = 0; i < 10; i++) step(sc(0, 0), 0, 1);
        expect_empty("R8 drained");
        finish_run();
    end
endmodule